// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit register with four operations picked each clock by two select inputs: keep the stored word, move it one place toward the most significant bit, move it one place toward the least significant bit, or take a whole new word from the parallel pins. Those parallel pins are shared. Whenever the bus drivers are on, the pins show the stored word. When they are off, an outside source may put a word on the same pins, and a load captures it.

The shared pins are modelled as three signals: `pin_in` (what the outside world drives), `pin_out` (what the block would drive) and `pin_drive` (whether the block drives). Either of two disable inputs switches the drivers off. Selecting the load operation also switches them off by itself, so the pins are free for incoming data. The two end bits are brought out on separate taps that are never switched off. Several instances can therefore be chained into a longer word by wiring each tap to the neighbour's serial input. An active-low reset clears the word at once, without waiting for a clock edge.

Top module: `ushift_bus_reg`

## Requirements
- R1: With `{sel1,sel0}` = 2'b00 the stored word is unchanged by a rising clock edge.
- R2: With `{sel1,sel0}` = 2'b01 a rising edge moves bit i into bit i+1, and `ser_r_in` enters bit 0.
- R3: With `{sel1,sel0}` = 2'b10 a rising edge moves bit i+1 into bit i, and `ser_l_in` enters bit W-1.
- R4: With `{sel1,sel0}` = 2'b11 a rising edge stores `pin_in`.
- R5: `pin_drive` is 1 exactly when `hiz_a` is 0, `hiz_b` is 0 and the selects are not 2'b11. While it is 1, `pin_out` equals the stored word.
- R6: Hold, both shifts and load act on the stored word in the same way when `pin_drive` is 0.
- R7: `tap_lo` always equals bit 0 and `tap_hi` always equals bit W-1 of the stored word, whatever the state of `pin_drive`.
- R8: While `rst_n` is 0 the stored word is zero, from the moment reset asserts and regardless of clock edges and selects.
- R9: Two instances chained (the low tap_hi to the high ser_r_in, and the high tap_lo to the low ser_l_in) shift as one 2W-bit word in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel0 | input | 1 | Operation select, low bit |
| sel1 | input | 1 | Operation select, high bit |
| hiz_a | input | 1 | High turns the parallel drivers off |
| hiz_b | input | 1 | High turns the parallel drivers off |
| ser_r_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_l_in | input | 1 | Serial bit entering bit W-1 on a downward shift |
| pin_in | input | W | Word present on the shared pins |
| pin_out | output | W | Word the block places on the shared pins |
| pin_drive | output | 1 | Block drives the shared pins |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Bit W-1, always driven |

## Verification
Two things can fall in the same cycle here: a register update and a switch of the bus drivers. A driver disable can coincide with a shift, and a reset can coincide with a load edge. The bench raises a disable input in the same cycles as shifts and loads. It checks that `pin_drive` drops while the word still moves, judged through the always-driven taps and through `pin_out` once the drivers come back. It also pulls reset low between edges with a load selected and valid data on the pins, and expects zero right away and again after the clock edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
    import ushift_pkg::*;
(
    input  logic sel0,
    input  logic sel1,
    input  logic hiz_a,
    input  logic hiz_b,
    output op_e  op,
    output logic bus_en
);

    always_comb begin
        op     = op_e'({sel1, sel0});
        bus_en = !hiz_a && !hiz_b && (op != OP_LOAD);
    end

endmodule

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_e          op,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] word
);

    localparam int TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] bits;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_KEEP: st_d.bits = st_q.bits;
            OP_UP:   st_d.bits = {st_q.bits[TOP-1:0], ser_r_in};
            OP_DOWN: st_d.bits = {ser_l_in, st_q.bits[TOP:1]};
            OP_LOAD: st_d.bits = par_in;
            default: st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.bits;

    assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_KEEP) |=> $stable(word));

    assert_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UP) |=> (word == {$past(word[TOP-1:0]), $past(ser_r_in)}));

    assert_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN) |=> (word == {$past(ser_l_in), $past(word[TOP:1])}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (word == $past(par_in)));

endmodule

// File: rtl/ushift_bus_drv.sv
module ushift_bus_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] word,
    input  logic         bus_en,
    output logic [W-1:0] pin_out,
    output logic         pin_drive,
    output logic         tap_lo,
    output logic         tap_hi
);

    always_comb begin
        pin_out   = word;
        pin_drive = bus_en;
        tap_lo    = word[0];
        tap_hi    = word[W-1];
    end

endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel0,
    input  logic         sel1,
    input  logic         hiz_a,
    input  logic         hiz_b,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic         pin_drive,
    output logic         tap_lo,
    output logic         tap_hi
);

    op_e          op;
    logic         bus_en;
    logic [W-1:0] word;

    ushift_mode_dec u_dec (
        .sel0   (sel0),
        .sel1   (sel1),
        .hiz_a  (hiz_a),
        .hiz_b  (hiz_b),
        .op     (op),
        .bus_en (bus_en)
    );

    ushift_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ser_r_in (ser_r_in),
        .ser_l_in (ser_l_in),
        .par_in   (pin_in),
        .word     (word)
    );

    ushift_bus_drv #(.W(W)) u_drv (
        .word      (word),
        .bus_en    (bus_en),
        .pin_out   (pin_out),
        .pin_drive (pin_drive),
        .tap_lo    (tap_lo),
        .tap_hi    (tap_hi)
    );

    assert_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_a || hiz_b || (sel0 && sel1)) |-> !pin_drive);

    assert_tap_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 && sel1) |=> (tap_lo == $past(pin_in[0]) && tap_hi == $past(pin_in[W-1])));

endmodule

// File: tb/ushift_bus_reg_tb_top.sv
module ushift_bus_reg_tb_top;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel0 = 1'b0, sel1 = 1'b0, hiz_a = 1'b0, hiz_b = 1'b0;
    logic ext_r = 1'b0, ext_l = 1'b0;
    logic [2*W-1:0] bus_in = '0;

    logic [W-1:0] out_lo, out_hi;
    logic drv_lo, drv_hi, lo_tap_lo, lo_tap_hi, hi_tap_lo, hi_tap_hi;

    always #5 clk = ~clk;

    // R9: chained pair, dut_i holds bits 7:0, dut_hi_i holds bits 15:8
    ushift_bus_reg #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel0(sel0), .sel1(sel1),
        .hiz_a(hiz_a), .hiz_b(hiz_b),
        .ser_r_in(ext_r), .ser_l_in(hi_tap_lo),
        .pin_in(bus_in[W-1:0]), .pin_out(out_lo), .pin_drive(drv_lo),
        .tap_lo(lo_tap_lo), .tap_hi(lo_tap_hi));

    ushift_bus_reg #(.W(W)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .sel0(sel0), .sel1(sel1),
        .hiz_a(hiz_a), .hiz_b(hiz_b),
        .ser_r_in(lo_tap_hi), .ser_l_in(ext_l),
        .pin_in(bus_in[2*W-1:W]), .pin_out(out_hi), .pin_drive(drv_hi),
        .tap_lo(hi_tap_lo), .tap_hi(hi_tap_hi));

    typedef struct {
        logic [2*W-1:0] val;
        logic           drv;
        string          tag;
    } exp_t;

    exp_t q[$];
    logic [2*W-1:0] model = '0;
    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [2*W-1:0] v, input logic d, input string tag);
        check({hi_tap_hi, hi_tap_lo, lo_tap_hi, lo_tap_lo} == {v[2*W-1], v[W], v[W-1], v[0]},
              {tag, " R7 taps"},
              {hi_tap_hi, hi_tap_lo, lo_tap_hi, lo_tap_lo}, {v[2*W-1], v[W], v[W-1], v[0]});
        check(drv_lo == d && drv_hi == d, {tag, " R5 drive"}, {drv_hi, drv_lo}, {d, d});
        if (d) check({out_hi, out_lo} == v, {tag, " pins"}, {out_hi, out_lo}, v);
    endtask

    // driver: apply one operation at the falling edge and queue the expected result
    task automatic step(input logic [1:0] sel, input logic r, input logic l,
                        input logic ha, input logic hb, input logic [2*W-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        {sel1, sel0} = sel;
        ext_r = r; ext_l = l; hiz_a = ha; hiz_b = hb;
        bus_in = (sel == 2'b11) ? d : 'x;
        case (sel)
            2'b00: model = model;
            2'b01: model = {model[2*W-2:0], r};
            2'b10: model = {l, model[2*W-1:1]};
            default: model = d;
        endcase
        e.val = model;
        e.drv = !ha && !hb && (sel != 2'b11);
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                look(e.val, e.drv, e.tag);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        look('0, 1'b1, "R8 reset state");
        rst_n = 1'b1;

        step(2'b11, 0, 0, 0, 0, 16'hA5C3, "R4 load");
        step(2'b00, 0, 0, 0, 0, '0, "R1 keep");
        step(2'b00, 1, 1, 0, 0, '0, "R1 keep serial ignored");
        step(2'b01, 1, 0, 0, 0, '0, "R2 R9 up 1");
        step(2'b01, 0, 1, 0, 0, '0, "R2 R9 up 0");
        step(2'b01, 1, 0, 0, 0, '0, "R2 R9 up 1b");
        for (int i = 0; i < 9; i++) step(2'b01, i[0], 0, 0, 0, '0, "R9 carry up");
        step(2'b10, 1, 0, 0, 0, '0, "R3 R9 down 0");
        step(2'b10, 0, 1, 0, 0, '0, "R3 R9 down 1");
        for (int i = 0; i < 9; i++) step(2'b10, 0, i[1], 0, 0, '0, "R9 carry down");
        step(2'b11, 0, 0, 0, 0, 16'h8001, "R4 load ends");
        step(2'b01, 0, 0, 1, 0, '0, "R6 up under hiz_a");
        step(2'b10, 0, 1, 0, 1, '0, "R6 down under hiz_b");
        step(2'b11, 0, 0, 1, 1, 16'h3C5A, "R6 load under hiz");
        step(2'b00, 0, 0, 1, 0, '0, "R5 keep hiz_a");
        step(2'b00, 0, 0, 0, 1, '0, "R5 keep hiz_b");
        step(2'b00, 0, 0, 0, 0, '0, "R5 R6 bus back");
        step(2'b11, 0, 0, 0, 0, 16'hFFFF, "R4 load ones");
        step(2'b00, 0, 0, 0, 0, '0, "R1 keep ones");
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0;
        #1;

        // R8: asynchronous clear between edges, with a load pending
        @(negedge clk);
        {sel1, sel0} = 2'b11;
        bus_in = 16'h1234;
        #2;
        rst_n = 1'b0;
        #1;
        look('0, 1'b0, "R8 async clear");
        @(posedge clk);
        #2;
        look('0, 1'b0, "R8 edge during reset");
        @(negedge clk);
        {sel1, sel0} = 2'b00;
        #1;
        look('0, 1'b1, "R8 held zero");
        rst_n = 1'b1;
        model = '0;
        step(2'b01, 1, 0, 0, 0, '0, "R2 after reset");
        step(2'b00, 0, 0, 0, 0, '0, "R1 final");
        @(negedge clk);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule